// File: doc/BRIEF.md
# Serial Bus Target Address Recognizer

This block is the receive front end of a two-wire serial bus target (I2C target). It oversamples the clock and data lines on the system clock through a synchronizer, finds START and STOP conditions, shifts in the address phase and decides whether this device is being spoken to. Three kinds of selection are recognized: a 7-bit own address whose low bits can be reprogrammed, a 10-bit own address carried in a header byte plus a second byte, and the general call address. The block can only pull the data line low or let it go, so its single drive output is an open-drain enable.

Once selected for a write, the block acknowledges each byte and hands it to the core on a byte port with a one-cycle strobe. Once selected for a read, it loads a byte from the core, shifts it out most significant bit first and watches the controller's acknowledge to decide whether to continue. After a general call, two command bytes reload the programmable address bits from strap pins, and one of them also pulses a reset to the core.

Top module: `i2c_tgt_addr_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sda_oe`, `rx_valid`, `tx_load` and `sw_rst` are all 0.
- R2: A START is SDA going from 1 to 0 while SCL is 1 in the synchronized samples, a STOP is SDA going from 0 to 1 while SCL is 1; a STOP releases SDA and returns the block to idle, and a START always begins a new address byte.
- R3: When the first byte after a START carries the own 7-bit address in bits 7..1 (bit 7 sent first), the block holds `sda_oe` at 1 from the SCL fall after the eighth bit to the SCL fall after the ninth; `sda_oe` changes only on an SCL fall, a START or a STOP. The own 7-bit address is the upper bits of `ADDR7` with the low `PROG_W` bits taken from the programmable field.
- R4: With bit 0 of a matched address byte at 0 (write), every following byte is acknowledged and appears on `rx_data` with `rx_valid` high for one cycle, in the cycle the acknowledge drive starts.
- R5: With bit 0 of a matched address byte at 1 (read), `tx_data` is captured with a one-cycle `tx_load` at the SCL fall ending the address acknowledge, and its bits are driven most significant first, each changing at an SCL fall; SDA is released after the eighth bit.
- R6: During a read, SDA low at the ninth SCL rise makes the block load and send the next byte; SDA high (not-acknowledge) makes it release SDA and stay silent until the next START or STOP.
- R7: A first byte that matches nothing is not acknowledged, and no further byte is acknowledged or delivered until the next START or STOP.
- R8: The byte 0x00 is acknowledged as a general call when `GC_EN` is 1, and a following byte other than 0x06 or 0x04 is acknowledged and delivered on `rx_data`.
- R9: After a general call, the byte 0x06 is acknowledged, not delivered, reloads the programmable address field from `strap_i` and raises `sw_rst` for one cycle.
- R10: After a general call, the byte 0x04 is acknowledged, not delivered and reloads the programmable address field from `strap_i` with no `sw_rst` pulse.
- R11: A first byte 11110 a9 a8 0 whose a9 a8 equal bits 9..8 of `ADDR10`, followed by a byte equal to bits 7..0 of `ADDR10`, selects the block for writes with both bytes acknowledged; a mismatch in either byte is not acknowledged.
- R12: A header byte 11110 a9 a8 1 is acknowledged and starts a read only after a repeated START that follows a successful 10-bit write selection with no STOP between; otherwise it is not acknowledged.
- R13: A repeated START in the middle of any byte discards the bits shifted so far and begins a fresh address byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired AND) |
| strap_i | input | PROG_W | Strap value for the programmable address bits |
| tx_data | input | 8 | Byte to send on a read, captured at `tx_load` |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| rx_data | output | 8 | Last byte received in a write |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| tx_load | output | 1 | One-cycle strobe when `tx_data` is captured |
| sw_rst | output | 1 | One-cycle reset pulse from the general call reset command |

## Verification
Two functions meet in a single system clock cycle: on the SCL fall that closes a byte, the acknowledge drive, the byte strobe (or the general call command's reload and reset pulse) and the choice of the next phase all happen together, and on a repeated START the discard of a half-shifted byte coincides with the restart of address reception. The bench provokes the first with back-to-back write bytes and both general call commands, and the second by issuing a repeated START after three bits of an address byte and then addressing the block. A behavioural model in the bench follows the synchronized line samples and predicts every output on every clock, and each host transaction also checks the acknowledge bits and byte values it sees on the bus.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ADDR  = 3'd1,
      ST_ADDR2 = 3'd2,
      ST_GCMD  = 3'd3,
      ST_WR    = 3'd4,
      ST_RD    = 3'd5,
      ST_SKIP  = 3'd6
   } tgt_state_e;

   localparam logic [7:0] GC_ADDR_BYTE = 8'h00;
   localparam logic [7:0] GC_RESET_CMD = 8'h06;
   localparam logic [7:0] GC_PROG_CMD  = 8'h04;
   localparam logic [4:0] TEN_HDR_TAG  = 5'b11110;
   localparam int         BYTE_W       = 8;

   typedef struct packed {
      logic       ack;
      logic       deliver;
      logic       ten_set;
      logic       ten_clr;
      logic       prog_load;
      logic       core_rst;
      tgt_state_e next;
   } decode_t;

endpackage

// File: rtl/i2c_tgt_sampler.sv
module i2c_tgt_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt,
   output logic sda_now
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] scl_sh;
   logic [SYNC_STAGES-1:0] sda_sh;
   logic                   scl_q;
   logic                   sda_q;
   logic                   scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
         scl_q  <= scl_sh[SYNC_STAGES-1];
         sda_q  <= sda_sh[SYNC_STAGES-1];
      end
   end

   assign scl_s     = scl_sh[SYNC_STAGES-1];
   assign sda_now   = sda_sh[SYNC_STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_evt = scl_s & scl_q & sda_q & ~sda_now;
   assign stop_evt  = scl_s & scl_q & ~sda_q & sda_now;

endmodule

// File: rtl/i2c_tgt_addr_match.sv
module i2c_tgt_addr_match
   import i2c_tgt_pkg::*;
#(
   parameter logic [6:0] ADDR7  = 7'h2A,
   parameter int         PROG_W = 2,
   parameter bit         TEN_EN = 1'b1,
   parameter logic [9:0] ADDR10 = 10'h2A5,
   parameter bit         GC_EN  = 1'b1
) (
   input  logic [7:0]        byte_i,
   input  logic [PROG_W-1:0] prog_i,
   output logic              hit7,
   output logic              hit_gc,
   output logic              hit_hdr,
   output logic              hit_lo
);

   localparam int FIX_W = 7 - PROG_W;

   logic [6:0] own7;

   generate
      if (PROG_W < 1 || PROG_W > 6) begin : g_bad_prog
         $error("PROG_W must lie between 1 and 6");
      end
      if (ADDR7[6:3] == 4'b1111 || ADDR7[6:3] == 4'b0000) begin : g_bad_addr7
         $error("ADDR7 falls in a reserved address group");
      end
   endgenerate

   assign own7 = {ADDR7[6 -: FIX_W], prog_i};
   assign hit7 = (byte_i[7:1] == own7);

   generate
      if (GC_EN) begin : g_gc
         assign hit_gc = (byte_i == GC_ADDR_BYTE);
      end else begin : g_no_gc
         assign hit_gc = 1'b0;
      end

      if (TEN_EN) begin : g_ten
         assign hit_hdr = (byte_i[7:1] == {TEN_HDR_TAG, ADDR10[9:8]});
         assign hit_lo  = (byte_i == ADDR10[7:0]);
      end else begin : g_no_ten
         assign hit_hdr = 1'b0;
         assign hit_lo  = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/i2c_tgt_prog_reg.sv
module i2c_tgt_prog_reg #(
   parameter int               PROG_W    = 2,
   parameter logic [PROG_W-1:0] PROG_INIT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [PROG_W-1:0] strap_i,
   output logic [PROG_W-1:0] prog_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      prog_o <= PROG_INIT;
      else if (load_i) prog_o <= strap_i;
   end

   // R10
   prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(prog_o))
      else $error("programmable field changed without a load");

endmodule

// File: rtl/i2c_tgt_addr_rx.sv
module i2c_tgt_addr_rx
   import i2c_tgt_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter logic [6:0]        ADDR7       = 7'h2A,
   parameter int                PROG_W      = 2,
   parameter logic [PROG_W-1:0] PROG_INIT   = 2'b10,
   parameter bit                TEN_EN      = 1'b1,
   parameter logic [9:0]        ADDR10      = 10'h2A5,
   parameter bit                GC_EN       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [PROG_W-1:0] strap_i,
   input  logic [7:0]        tx_data,
   output logic              sda_oe,
   output logic [7:0]        rx_data,
   output logic              rx_valid,
   output logic              tx_load,
   output logic              sw_rst
);

   localparam int         CNT_W    = 4;
   localparam logic [3:0] LAST_BIT = 4'(BYTE_W);
   localparam logic [3:0] ACK_BIT  = 4'(BYTE_W + 1);

   logic              scl_rise, scl_fall, start_evt, stop_evt, sda_now;
   logic              hit7, hit_gc, hit_hdr, hit_lo;
   logic [PROG_W-1:0] prog;
   logic              prog_ld;

   tgt_state_e        state, pend;
   logic [CNT_W-1:0]  cnt;
   logic [7:0]        shreg;
   logic [7:0]        txreg;
   logic              ten_sel;
   logic              host_ack;
   decode_t           dec;

   i2c_tgt_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_evt (start_evt),
      .stop_evt  (stop_evt),
      .sda_now   (sda_now)
   );

   i2c_tgt_addr_match #(
      .ADDR7  (ADDR7),
      .PROG_W (PROG_W),
      .TEN_EN (TEN_EN),
      .ADDR10 (ADDR10),
      .GC_EN  (GC_EN)
   ) u_match (
      .byte_i  (shreg),
      .prog_i  (prog),
      .hit7    (hit7),
      .hit_gc  (hit_gc),
      .hit_hdr (hit_hdr),
      .hit_lo  (hit_lo)
   );

   i2c_tgt_prog_reg #(.PROG_W(PROG_W), .PROG_INIT(PROG_INIT)) u_prog (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (prog_ld),
      .strap_i (strap_i),
      .prog_o  (prog)
   );

   // Decision taken on the SCL fall that closes a received byte.
   always_comb begin
      dec = '{ack: 1'b0, deliver: 1'b0, ten_set: 1'b0, ten_clr: 1'b0,
              prog_load: 1'b0, core_rst: 1'b0, next: ST_SKIP};
      unique case (state)
         ST_ADDR: begin
            if (hit7) begin
               dec.ack     = 1'b1;
               dec.ten_clr = 1'b1;
               dec.next    = shreg[0] ? ST_RD : ST_WR;
            end else if (hit_gc) begin
               dec.ack     = 1'b1;
               dec.ten_clr = 1'b1;
               dec.next    = ST_GCMD;
            end else if (hit_hdr) begin
               if (!shreg[0]) begin
                  dec.ack  = 1'b1;
                  dec.next = ST_ADDR2;
               end else if (ten_sel) begin
                  dec.ack  = 1'b1;
                  dec.next = ST_RD;
               end
            end else begin
               dec.ten_clr = 1'b1;
            end
         end
         ST_ADDR2: begin
            if (hit_lo) begin
               dec.ack     = 1'b1;
               dec.ten_set = 1'b1;
               dec.next    = ST_WR;
            end else begin
               dec.ten_clr = 1'b1;
            end
         end
         ST_GCMD: begin
            dec.ack  = 1'b1;
            dec.next = ST_WR;
            if (shreg == GC_RESET_CMD) begin
               dec.prog_load = 1'b1;
               dec.core_rst  = 1'b1;
            end else if (shreg == GC_PROG_CMD) begin
               dec.prog_load = 1'b1;
            end else begin
               dec.deliver = 1'b1;
            end
         end
         ST_WR: begin
            dec.ack     = 1'b1;
            dec.deliver = 1'b1;
            dec.next    = ST_WR;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         pend     <= ST_IDLE;
         cnt      <= '0;
         shreg    <= '0;
         txreg    <= '0;
         ten_sel  <= 1'b0;
         host_ack <= 1'b0;
         sda_oe   <= 1'b0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
         tx_load  <= 1'b0;
         sw_rst   <= 1'b0;
         prog_ld  <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         tx_load  <= 1'b0;
         sw_rst   <= 1'b0;
         prog_ld  <= 1'b0;
         if (start_evt) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_evt) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            sda_oe  <= 1'b0;
            ten_sel <= 1'b0;
         end else if (state != ST_IDLE && state != ST_SKIP) begin
            if (scl_rise) begin
               if (cnt < LAST_BIT) shreg <= {shreg[6:0], sda_now};
               if (cnt == LAST_BIT && state == ST_RD) host_ack <= ~sda_now;
               if (cnt < ACK_BIT) cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
               if (state == ST_RD) begin
                  if (cnt >= 4'd1 && cnt < LAST_BIT) begin
                     sda_oe <= ~txreg[6];
                     txreg  <= {txreg[6:0], 1'b0};
                  end else if (cnt == LAST_BIT) begin
                     sda_oe <= 1'b0;
                  end else if (cnt == ACK_BIT) begin
                     if (host_ack) begin
                        txreg   <= tx_data;
                        sda_oe  <= ~tx_data[7];
                        tx_load <= 1'b1;
                        cnt     <= '0;
                     end else begin
                        state  <= ST_SKIP;
                        sda_oe <= 1'b0;
                     end
                  end
               end else if (cnt == LAST_BIT) begin
                  sda_oe   <= dec.ack;
                  pend     <= dec.next;
                  rx_valid <= dec.deliver;
                  if (dec.deliver) rx_data <= shreg;
                  prog_ld  <= dec.prog_load;
                  sw_rst   <= dec.core_rst;
                  if (dec.ten_set) ten_sel <= 1'b1;
                  else if (dec.ten_clr) ten_sel <= 1'b0;
                  if (!dec.ack) state <= ST_SKIP;
               end else if (cnt == ACK_BIT) begin
                  cnt   <= '0;
                  state <= pend;
                  if (pend == ST_RD) begin
                     txreg   <= tx_data;
                     sda_oe  <= ~tx_data[7];
                     tx_load <= 1'b1;
                  end else begin
                     sda_oe <= 1'b0;
                  end
               end
            end
         end
      end
   end

   // R3
   oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(scl_fall || start_evt || stop_evt) |=> $stable(sda_oe))
      else $error("data drive changed away from an SCL fall or bus condition");

   // R2
   stop_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> (!sda_oe && state == ST_IDLE))
      else $error("STOP did not release the bus");

   // R4
   rxv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid)
      else $error("byte strobe longer than one cycle");

   // R9
   swrst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst |=> !sw_rst)
      else $error("core reset pulse longer than one cycle");

   // R5
   txload_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |-> $past(scl_fall))
      else $error("transmit byte captured away from an SCL fall");

   // R7
   skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP && !start_evt && !stop_evt) |=> (!sda_oe && !rx_valid && !tx_load))
      else $error("unselected target touched the bus or the core");

endmodule

// File: tb/i2c_tgt_addr_rx_tb.sv
module i2c_tgt_addr_rx_tb;

   localparam int         CLK_PERIOD = 10;
   localparam int         QTR        = 6;
   localparam logic [6:0] ADDR7      = 7'h2A;
   localparam logic [9:0] ADDR10     = 10'h2A5;
   localparam logic [1:0] PROG_INIT  = 2'b10;

   localparam int M_IDLE = 0, M_ADR = 1, M_ADR2 = 2, M_GC = 3, M_WR = 4, M_RD = 5, M_SKIP = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_h = 1'b1;
   logic       sda_h = 1'b1;
   logic [1:0] strap = 2'b00;
   logic [7:0] tx_data = 8'h00;
   logic       sda_oe, rx_valid, tx_load, sw_rst;
   logic [7:0] rx_data;
   wire        sda_bus = sda_h & ~sda_oe;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_tgt_addr_rx u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_h),
      .sda_i    (sda_bus),
      .strap_i  (strap),
      .tx_data  (tx_data),
      .sda_oe   (sda_oe),
      .rx_data  (rx_data),
      .rx_valid (rx_valid),
      .tx_load  (tx_load),
      .sw_rst   (sw_rst)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit   m_c1, m_c2, m_cp, m_d1, m_d2, m_dp;
   int   md, nxt, nb;
   int   sh;
   logic [7:0] tx;
   bit   hack, m_ten, m_pld;
   logic [1:0] m_prog;
   bit   e_sda, e_rxv, e_txl, e_swr;
   logic [7:0] e_rxd;

   always @(posedge clk) begin
      bit rs, fl, stv, spv, ack;
      int own7, hdr;
      if (!rst_n) begin
         m_c1 = 1; m_c2 = 1; m_cp = 1; m_d1 = 1; m_d2 = 1; m_dp = 1;
         md = M_IDLE; nxt = M_IDLE; nb = 0; sh = 0; tx = 0;
         hack = 0; m_ten = 0; m_pld = 0; m_prog = PROG_INIT;
         e_sda = 0; e_rxv = 0; e_txl = 0; e_swr = 0; e_rxd = 0;
      end else begin
         rs  = m_c2 && !m_cp;
         fl  = !m_c2 && m_cp;
         stv = m_c2 && m_cp && m_dp && !m_d2;
         spv = m_c2 && m_cp && !m_dp && m_d2;
         e_rxv = 0; e_txl = 0; e_swr = 0;
         if (m_pld) begin m_prog = strap; m_pld = 0; end
         if (stv) begin
            md = M_ADR; nb = 0; e_sda = 0;
         end else if (spv) begin
            md = M_IDLE; nb = 0; e_sda = 0; m_ten = 0;
         end else if (md != M_IDLE && md != M_SKIP) begin
            if (rs) begin
               if (nb < 8) sh = ((sh << 1) | int'(m_d2)) & 255;
               if (nb == 8 && md == M_RD) hack = !m_d2;
               if (nb < 9) nb++;
            end else if (fl) begin
               if (md == M_RD) begin
                  if (nb >= 1 && nb <= 7) e_sda = !tx[7-nb];
                  else if (nb == 8) e_sda = 0;
                  else if (nb == 9) begin
                     if (hack) begin tx = tx_data; e_sda = !tx[7]; e_txl = 1; nb = 0; end
                     else begin md = M_SKIP; e_sda = 0; end
                  end
               end else if (nb == 8) begin
                  ack  = 0;
                  own7 = (int'(ADDR7) & 'h7C) | int'(m_prog);
                  hdr  = ('b11110 << 2) | int'(ADDR10 >> 8);
                  case (md)
                     M_ADR: begin
                        if ((sh >> 1) == own7) begin ack = 1; nxt = (sh & 1) ? M_RD : M_WR; m_ten = 0; end
                        else if (sh == 0) begin ack = 1; nxt = M_GC; m_ten = 0; end
                        else if ((sh >> 1) == hdr) begin
                           if ((sh & 1) == 0) begin ack = 1; nxt = M_ADR2; end
                           else if (m_ten) begin ack = 1; nxt = M_RD; end
                        end else m_ten = 0;
                     end
                     M_ADR2: begin
                        if (sh == int'(ADDR10 & 10'hFF)) begin ack = 1; nxt = M_WR; m_ten = 1; end
                        else m_ten = 0;
                     end
                     M_GC: begin
                        ack = 1; nxt = M_WR;
                        if (sh == 6) begin m_pld = 1; e_swr = 1; end
                        else if (sh == 4) m_pld = 1;
                        else begin e_rxv = 1; e_rxd = 8'(sh); end
                     end
                     default: begin ack = 1; nxt = M_WR; e_rxv = 1; e_rxd = 8'(sh); end
                  endcase
                  e_sda = ack;
                  if (!ack) md = M_SKIP;
               end else if (nb == 9) begin
                  nb = 0; md = nxt;
                  if (md == M_RD) begin tx = tx_data; e_sda = !tx[7]; e_txl = 1; end
                  else e_sda = 0;
               end
            end
         end
         m_cp = m_c2; m_c2 = m_c1; m_c1 = scl_h;
         m_dp = m_d2; m_d2 = m_d1; m_d1 = sda_bus;
      end
   end

   // per-cycle comparison and byte collection
   logic [7:0] rxq[$];
   int swr_cnt = 0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(sda_oe == e_sda, "R3 sda_oe vs model", sda_oe, e_sda);
         chk(rx_valid == e_rxv && (!e_rxv || rx_data == e_rxd), "R4 rx strobe/data vs model",
             {rx_valid, rx_data}, {e_rxv, e_rxd});
         chk(tx_load == e_txl, "R5 tx_load vs model", tx_load, e_txl);
         chk(sw_rst == e_swr, "R9 sw_rst vs model", sw_rst, e_swr);
         if (rx_valid) rxq.push_back(rx_data);
         if (sw_rst) swr_cnt++;
      end
   end

   // ---------------- host side ----------------
   task automatic wq();
      repeat (QTR) @(negedge clk);
   endtask

   task automatic h_start();
      sda_h = 1; scl_h = 1; wq(); sda_h = 0; wq(); scl_h = 0; wq();
   endtask

   task automatic h_rstart();
      sda_h = 1; wq(); scl_h = 1; wq(); sda_h = 0; wq(); scl_h = 0; wq();
   endtask

   task automatic h_stop();
      sda_h = 0; wq(); scl_h = 1; wq(); sda_h = 1; wq(); wq();
   endtask

   task automatic h_wbit(input bit b);
      sda_h = b; wq(); scl_h = 1; wq(); wq(); scl_h = 0; wq();
   endtask

   task automatic h_rbit(output bit b);
      sda_h = 1; wq(); scl_h = 1; wq(); b = sda_bus; wq(); scl_h = 0; wq();
   endtask

   task automatic h_wbyte(input logic [7:0] v, output bit acked);
      bit b;
      for (int i = 7; i >= 0; i--) h_wbit(v[i]);
      h_rbit(b);
      acked = !b;
   endtask

   task automatic h_rbyte(output logic [7:0] v, input bit give_ack);
      bit b;
      for (int i = 7; i >= 0; i--) begin h_rbit(b); v[i] = b; end
      h_wbit(!give_ack);
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit a;
      logic [7:0] v;
      int n0, s0;

      repeat (3) @(negedge clk);
      // R1 reset state
      chk({sda_oe, rx_valid, tx_load, sw_rst} == 4'b0, "R1 outputs during reset",
          {sda_oe, rx_valid, tx_load, sw_rst}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({sda_oe, rx_valid, tx_load, sw_rst} == 4'b0, "R1 outputs after reset",
          {sda_oe, rx_valid, tx_load, sw_rst}, 0);
      wq();

      // R3 / R4: 7-bit write
      h_start();
      h_wbyte(8'h54, a); chk(a, "R3 own 7-bit write address acked", a, 1);
      h_wbyte(8'hA5, a); chk(a, "R4 data byte 1 acked", a, 1);
      h_wbyte(8'h3C, a); chk(a, "R4 data byte 2 acked", a, 1);
      h_stop();
      chk(rxq.size() == 2, "R4 byte count", rxq.size(), 2);
      if (rxq.size() == 2) begin
         chk(rxq[0] == 8'hA5, "R4 first byte", rxq[0], 8'hA5);
         chk(rxq[1] == 8'h3C, "R4 second byte", rxq[1], 8'h3C);
      end
      rxq.delete();

      // R7: mismatch then ignored bytes
      h_start();
      h_wbyte(8'h60, a); chk(!a, "R7 foreign address not acked", a, 0);
      h_wbyte(8'h54, a); chk(!a, "R7 later byte ignored", a, 0);
      h_stop();
      chk(rxq.size() == 0, "R7 nothing delivered", rxq.size(), 0);

      // R5 / R6: read, ack then nack
      tx_data = 8'hC3;
      h_start();
      h_wbyte(8'h55, a); chk(a, "R5 read address acked", a, 1);
      tx_data = 8'h5A;
      h_rbyte(v, 1'b1); chk(v == 8'hC3, "R5 first read byte", v, 8'hC3);
      tx_data = 8'h96;
      h_rbyte(v, 1'b0); chk(v == 8'h5A, "R6 byte after host ack", v, 8'h5A);
      h_rbyte(v, 1'b1); chk(v == 8'hFF, "R6 silent after host nack", v, 8'hFF);
      h_stop();

      // R8: general call with plain data byte
      h_start();
      h_wbyte(8'h00, a); chk(a, "R8 general call acked", a, 1);
      h_wbyte(8'h37, a); chk(a, "R8 second byte acked", a, 1);
      h_stop();
      chk(rxq.size() == 1 && rxq[0] == 8'h37, "R8 second byte delivered",
          rxq.size() ? int'(rxq[0]) : -1, 8'h37);
      rxq.delete();

      // R13: repeated START after three bits
      h_start();
      h_wbit(1'b1); h_wbit(1'b0); h_wbit(1'b1);
      h_rstart();
      h_wbyte(8'h54, a); chk(a, "R13 address after mid-byte restart acked", a, 1);
      h_wbyte(8'h81, a);
      h_stop();
      chk(rxq.size() == 1 && rxq[0] == 8'h81, "R13 byte after restart",
          rxq.size() ? int'(rxq[0]) : -1, 8'h81);
      rxq.delete();

      // R9: general call reset command
      strap = 2'b01;
      s0 = swr_cnt;
      h_start();
      h_wbyte(8'h00, a);
      h_wbyte(8'h06, a); chk(a, "R9 reset command acked", a, 1);
      h_stop();
      chk(swr_cnt == s0 + 1, "R9 one reset pulse", swr_cnt - s0, 1);
      chk(rxq.size() == 0, "R9 command not delivered", rxq.size(), 0);
      h_start(); h_wbyte(8'h52, a); h_stop();
      chk(a, "R9 reloaded address 0x29 acked", a, 1);
      h_start(); h_wbyte(8'h54, a); h_stop();
      chk(!a, "R9 old address 0x2A no longer acked", a, 0);

      // R10: general call program command
      strap = 2'b11;
      s0 = swr_cnt;
      h_start();
      h_wbyte(8'h00, a);
      h_wbyte(8'h04, a); chk(a, "R10 program command acked", a, 1);
      h_stop();
      chk(swr_cnt == s0, "R10 no reset pulse", swr_cnt - s0, 0);
      h_start(); h_wbyte(8'h56, a); h_stop();
      chk(a, "R10 reloaded address 0x2B acked", a, 1);

      // R11: 10-bit write and mismatches
      n0 = rxq.size();
      h_start();
      h_wbyte(8'hF4, a); chk(a, "R11 10-bit header acked", a, 1);
      h_wbyte(8'hA5, a); chk(a, "R11 10-bit low byte acked", a, 1);
      h_wbyte(8'h11, a); chk(a, "R11 data after 10-bit select", a, 1);
      // R12: repeated START read after selection
      tx_data = 8'h3E;
      h_rstart();
      h_wbyte(8'hF5, a); chk(a, "R12 10-bit read header acked", a, 1);
      h_rbyte(v, 1'b0); chk(v == 8'h3E, "R12 10-bit read byte", v, 8'h3E);
      h_stop();
      chk(rxq.size() == n0 + 1 && rxq[n0] == 8'h11, "R11 data byte delivered",
          rxq.size() > n0 ? int'(rxq[n0]) : -1, 8'h11);
      h_start(); h_wbyte(8'hF4, a); h_wbyte(8'hA4, a); h_stop();
      chk(!a, "R11 wrong low byte not acked", a, 0);
      h_start(); h_wbyte(8'hF2, a); h_stop();
      chk(!a, "R11 wrong high bits not acked", a, 0);
      h_start(); h_wbyte(8'hF5, a); h_stop();
      chk(!a, "R12 read header without selection not acked", a, 0);

      // R2: STOP mid-byte releases and idles
      h_start(); h_wbyte(8'h56, a); h_wbit(1'b0); h_wbit(1'b1);
      h_stop();
      wq();
      chk(sda_oe == 1'b0, "R2 released after STOP", sda_oe, 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule